// File: doc/BRIEF.md
# Stereo Audio Serial Transmitter

This block feeds an external stereo audio DAC from a stream of packed sample words. Each 32-bit input word holds one stereo sample. The left channel is in the upper half and the right channel is in the lower half. Each channel arrives as two bytes in little-endian order. The block runs on the master audio clock and divides it by a fixed integer to make the bit clock. The word-select clock is the bit clock divided by the 32 bit slots of one frame. With the default division of 8 and a master clock of 11.2896 MHz, the bit clock is 1.4112 MHz and word select runs at 44.1 kHz.

At each frame boundary the block takes one word from a ready/valid source. It reorders the bytes of each channel so the most significant byte comes first. It then shifts the frame out most-significant bit first: left channel, then right. Serial data and word select change only when the bit clock falls, so the DAC can sample both on the rising edge. A static format input selects one of two framings:
- Left-justified: word select is high for the left channel, and the MSB appears in the first bit slot.
- I2S: word select is low for the left channel, and every channel is delayed by one bit slot.

If the source has no word ready at a frame boundary, the block sends a silent frame and sets a sticky flag.

Top module: `stereo_ser_tx`

## Requirements
- R1: While `rst` is high, and on the first clock after it, `bclk_o`, `ws_o`, `sd_o`, `s_ready` and `underflow_o` are all low.
- R2: `bclk_o` is a square wave with a period of `MCLK_PER_BCLK` clocks (default 8). It is high for half of that period and low for the other half.
- R3: `ws_o` has a period of 32 bit-clock periods (256 clocks by default). `ws_o` and `sd_o` change only in the clock cycle in which `bclk_o` falls.
- R4: `s_ready` is high for exactly one clock per frame. A word offered with `s_valid` high in that cycle becomes the next frame, so consecutive words go to consecutive frames.
- R5: Bits 31:16 of the word are the left channel and bits 15:0 are the right channel. Within each channel, the byte in the upper position is the low-order sample byte, so the value sent is {half[7:0], half[15:8]}. The left channel is sent first, MSB first.
- R6: With `fmt_i2s` = 0 (left-justified), `ws_o` is high for the 16 left-channel bits and low for the 16 right-channel bits. The bit sampled on the first bit-clock rise after `ws_o` rises is bit 15 of the swapped left channel.
- R7: With `fmt_i2s` = 1 (I2S), `ws_o` is low for the left channel and high for the right channel. The bit sampled on the first rise after a `ws_o` edge is the LSB of the previous channel. The new channel's MSB follows on the next rise.
- R8: If `s_valid` is low while `s_ready` is high, the frame is sent as all zeros and `underflow_o` goes high. `underflow_o` then stays high until reset, even after valid words arrive again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master audio clock |
| rst | input | 1 | Synchronous active-high reset |
| fmt_i2s | input | 1 | Static framing select: 0 left-justified, 1 I2S |
| s_data | input | 32 | Packed stereo word, left in upper half, little-endian bytes per channel |
| s_valid | input | 1 | Source has a word on `s_data` |
| s_ready | output | 1 | One-cycle pulse per frame; word taken when `s_valid` is high |
| bclk_o | output | 1 | Bit clock to the DAC |
| ws_o | output | 1 | Word-select (channel) clock to the DAC |
| sd_o | output | 1 | Serial sample data to the DAC |
| underflow_o | output | 1 | Sticky flag: a frame boundary found no valid word |

## Verification
The bench reconstructs frames from the serial lines by sampling on each rising edge of `bclk_o`, the same way the DAC does. The test words are chosen so that specific mistakes produce visibly different frames:
- Words such as 0x34FF_1280 and 0x0180_FE7F have different bytes in each half. A missing or misplaced byte swap, a left/right exchange, or a reversed bit order each produces a different wrong frame.
- Running the same words in both framings shows whether the one-slot delay and the word-select polarity are correct. In I2S mode, the slot at each `ws_o` edge must carry the LSB of the previous channel.
- A period with no valid words checks the silent frame, the sticky flag, and that a later word still lands in the next frame.

// File: rtl/stx_pkg.sv
package stx_pkg;

  typedef enum logic {
    FMT_LEFT_JUST = 1'b0,
    FMT_I2S       = 1'b1
  } frame_fmt_e;

  localparam int unsigned NUM_CH = 2;

endpackage

// File: rtl/stx_bclk_gen.sv
// Divides the master clock into the bit clock and flags the cycle
// before the falling edge (outputs update there) and the one before it.
module stx_bclk_gen #(
  parameter int unsigned DIV = 8   // even, at least 4
) (
  input  logic clk,
  input  logic rst,
  output logic bclk_o,
  output logic fall_tick,
  output logic pre_fall
);
  localparam int unsigned DW   = $clog2(DIV);
  localparam int unsigned HALF = DIV / 2;

  logic [DW-1:0] div_cnt;

  assign fall_tick = (div_cnt == DW'(DIV - 1));
  assign pre_fall  = (div_cnt == DW'(DIV - 2));

  always_ff @(posedge clk) begin
    if (rst) begin
      div_cnt <= '0;
      bclk_o  <= 1'b0;
    end else begin
      if (fall_tick) div_cnt <= '0;
      else           div_cnt <= div_cnt + 1'b1;

      if (div_cnt == DW'(HALF - 1)) bclk_o <= 1'b1;
      else if (fall_tick)           bclk_o <= 1'b0;
    end
  end
endmodule

// File: rtl/stx_framer.sv
// Tracks the bit slot of the frame with a down-counter, handshakes one
// word per frame, swaps the bytes of every channel and records underflow.
module stx_framer #(
  parameter int unsigned CH_W = 16
) (
  input  logic                                   clk,
  input  logic                                   rst,
  input  logic                                   fall_tick,
  input  logic                                   pre_fall,
  input  logic [stx_pkg::NUM_CH*CH_W-1:0]        s_data,
  input  logic                                   s_valid,
  output logic                                   s_ready,
  output logic                                   underflow_o,
  output logic [$clog2(stx_pkg::NUM_CH*CH_W)-1:0] next_slot,
  output logic [stx_pkg::NUM_CH*CH_W-1:0]        word_nxt
);
  localparam int unsigned FW = stx_pkg::NUM_CH * CH_W;
  localparam int unsigned SW = $clog2(FW);
  localparam int unsigned NB = CH_W / 8;

  logic [SW-1:0] slot_cnt;
  logic [FW-1:0] word_q;
  logic [FW-1:0] swapped;
  logic          frame_start;

  for (genvar ch = 0; ch < stx_pkg::NUM_CH; ch++) begin : g_ch
    for (genvar b = 0; b < NB; b++) begin : g_byte
      assign swapped[ch*CH_W + b*8 +: 8] = s_data[ch*CH_W + (NB-1-b)*8 +: 8];
    end
  end

  assign frame_start = fall_tick && (slot_cnt == '0);
  assign next_slot   = (slot_cnt == '0) ? SW'(FW - 1) : slot_cnt - 1'b1;
  assign word_nxt    = frame_start ? (s_valid ? swapped : '0) : word_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      slot_cnt    <= '0;
      word_q      <= '0;
      s_ready     <= 1'b0;
      underflow_o <= 1'b0;
    end else begin
      s_ready <= pre_fall && (slot_cnt == '0);
      if (fall_tick) slot_cnt <= next_slot;
      if (frame_start) begin
        word_q <= word_nxt;
        if (!s_valid) underflow_o <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/stx_serializer.sv
// Drives word select and serial data at each bit-clock fall; I2S framing
// delays the data stream by one slot through a single register.
module stx_serializer #(
  parameter int unsigned FW = 32
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  fall_tick,
  input  stx_pkg::frame_fmt_e   fmt,
  input  logic [$clog2(FW)-1:0] next_slot,
  input  logic [FW-1:0]         word_nxt,
  output logic                  ws_o,
  output logic                  sd_o
);
  localparam int unsigned SW = $clog2(FW);

  logic lj_bit;
  logic lj_q;
  logic left_half;

  assign lj_bit    = word_nxt[next_slot];
  assign left_half = (next_slot >= SW'(FW / 2));

  always_ff @(posedge clk) begin
    if (rst) begin
      ws_o <= 1'b0;
      sd_o <= 1'b0;
      lj_q <= 1'b0;
    end else if (fall_tick) begin
      lj_q <= lj_bit;
      if (fmt == stx_pkg::FMT_I2S) begin
        sd_o <= lj_q;
        ws_o <= ~left_half;
      end else begin
        sd_o <= lj_bit;
        ws_o <= left_half;
      end
    end
  end
endmodule

// File: rtl/stereo_ser_tx.sv
module stereo_ser_tx #(
  parameter int unsigned MCLK_PER_BCLK = 8,
  parameter int unsigned CH_W          = 16
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             fmt_i2s,
  input  logic [stx_pkg::NUM_CH*CH_W-1:0]  s_data,
  input  logic                             s_valid,
  output logic                             s_ready,
  output logic                             bclk_o,
  output logic                             ws_o,
  output logic                             sd_o,
  output logic                             underflow_o
);
  localparam int unsigned FW = stx_pkg::NUM_CH * CH_W;
  localparam int unsigned SW = $clog2(FW);

  logic          fall_tick;
  logic          pre_fall;
  logic [SW-1:0] next_slot;
  logic [FW-1:0] word_nxt;
  stx_pkg::frame_fmt_e fmt;

  assign fmt = stx_pkg::frame_fmt_e'(fmt_i2s);

  stx_bclk_gen #(.DIV(MCLK_PER_BCLK)) u_bclk (
    .clk       (clk),
    .rst       (rst),
    .bclk_o    (bclk_o),
    .fall_tick (fall_tick),
    .pre_fall  (pre_fall)
  );

  stx_framer #(.CH_W(CH_W)) u_framer (
    .clk         (clk),
    .rst         (rst),
    .fall_tick   (fall_tick),
    .pre_fall    (pre_fall),
    .s_data      (s_data),
    .s_valid     (s_valid),
    .s_ready     (s_ready),
    .underflow_o (underflow_o),
    .next_slot   (next_slot),
    .word_nxt    (word_nxt)
  );

  stx_serializer #(.FW(FW)) u_ser (
    .clk       (clk),
    .rst       (rst),
    .fall_tick (fall_tick),
    .fmt       (fmt),
    .next_slot (next_slot),
    .word_nxt  (word_nxt),
    .ws_o      (ws_o),
    .sd_o      (sd_o)
  );
endmodule

// File: rtl/stx_checker.sv
module stx_checker #(
  parameter int unsigned MCLK_PER_BCLK = 8
) (
  input logic clk,
  input logic rst,
  input logic s_valid,
  input logic s_ready,
  input logic bclk_o,
  input logic ws_o,
  input logic sd_o,
  input logic underflow_o
);
  localparam int unsigned HALF = MCLK_PER_BCLK / 2;

  logic        prev_b;
  logic        seen;
  int unsigned hold;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_b <= 1'b0;
      seen   <= 1'b0;
      hold   <= 0;
    end else begin
      prev_b <= bclk_o;
      if (bclk_o != prev_b) begin
        hold <= 0;
        seen <= 1'b1;
      end else begin
        hold <= hold + 1;
      end
    end
  end

  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> (!bclk_o && !ws_o && !sd_o && !s_ready && !underflow_o));

  a_r2_bclk_half: assert property (@(posedge clk) disable iff (rst)
    (seen && (bclk_o != prev_b)) |-> (hold == HALF - 1));

  a_r3_ws_on_fall: assert property (@(posedge clk) disable iff (rst)
    !$stable(ws_o) |-> $fell(bclk_o));

  a_r3_sd_on_fall: assert property (@(posedge clk) disable iff (rst)
    !$stable(sd_o) |-> $fell(bclk_o));

  a_r4_ready_single: assert property (@(posedge clk) disable iff (rst)
    s_ready |=> !s_ready);

  a_r8_underflow_set: assert property (@(posedge clk) disable iff (rst)
    (s_ready && !s_valid) |=> underflow_o);

  a_r8_underflow_sticky: assert property (@(posedge clk) disable iff (rst)
    underflow_o |=> underflow_o);
endmodule

bind stereo_ser_tx stx_checker #(.MCLK_PER_BCLK(MCLK_PER_BCLK)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .s_valid     (s_valid),
  .s_ready     (s_ready),
  .bclk_o      (bclk_o),
  .ws_o        (ws_o),
  .sd_o        (sd_o),
  .underflow_o (underflow_o)
);

// File: tb/stereo_ser_tx_bench.sv
module stereo_ser_tx_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        fmt_i2s = 1'b0;
  logic [31:0] s_data;
  logic        s_valid;
  logic        s_ready, bclk_o, ws_o, sd_o, underflow_o;

  always #2 clk = ~clk;

  stereo_ser_tx u_stereo_ser_tx (
    .clk(clk), .rst(rst), .fmt_i2s(fmt_i2s), .s_data(s_data),
    .s_valid(s_valid), .s_ready(s_ready), .bclk_o(bclk_o), .ws_o(ws_o),
    .sd_o(sd_o), .underflow_o(underflow_o)
  );

  int checks = 0;
  int fails  = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // source model
  logic [31:0] words [4];
  int  widx = 0;
  int  nwords = 0;
  bit  feed_en = 1'b0;
  bit  rdy_seen = 1'b0;
  assign s_data  = words[widx % 4];
  assign s_valid = feed_en && (widx < nwords);

  always @(negedge clk) begin
    if (rdy_seen) widx++;
    rdy_seen = s_ready;
  end

  // DAC-side capture on each bit-clock rise
  bit ws_a [320];
  bit sd_a [320];
  int ncap = 0;
  int viol = 0;
  bit bclk_prev = 1'b0, ws_prev = 1'b0, sd_prev = 1'b0;

  always @(negedge clk) begin
    if (!rst) begin
      if (bclk_o && !bclk_prev && ncap < 320) begin
        ws_a[ncap] = ws_o;
        sd_a[ncap] = sd_o;
        ncap++;
      end
      if (((ws_o != ws_prev) || (sd_o != sd_prev)) && !(bclk_prev && !bclk_o))
        viol++;
    end
    bclk_prev = bclk_o;
    ws_prev   = ws_o;
    sd_prev   = sd_o;
  end

  function automatic logic [15:0] sw16(input logic [15:0] h);
    return {h[7:0], h[15:8]};
  endfunction

  function automatic logic [31:0] exp_frame(input logic [31:0] w);
    return {sw16(w[31:16]), sw16(w[15:0])};
  endfunction

  function automatic logic [31:0] get_bits(input int start);
    logic [31:0] v = '0;
    for (int k = 0; k < 32; k++) v = {v[30:0], sd_a[start + k]};
    return v;
  endfunction

  function automatic int find_edge(input bit rising);
    for (int k = 1; k < ncap; k++)
      if (ws_a[k] == rising && ws_a[k-1] == !rising) return k;
    return -1;
  endfunction

  function automatic int ws_count(input int start, input int len, input bit val);
    int c = 0;
    for (int k = start; k < start + len; k++) if (ws_a[k] == val) c++;
    return c;
  endfunction

  task automatic do_reset(input bit i2s, input bit feed);
    @(negedge clk);
    rst = 1'b1;
    fmt_i2s = i2s;
    feed_en = feed;
    widx = 0;
    rdy_seen = 1'b0;
    repeat (4) @(negedge clk);
    ncap = 0;
    viol = 0;
    rst = 1'b0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    rst = 1'b1;
    feed_en = 1'b1;
    repeat (3) @(negedge clk);
    check(!bclk_o, "R1", "bclk_o in reset", bclk_o, 0);
    check(!ws_o && !sd_o, "R1", "ws_o/sd_o in reset", {ws_o, sd_o}, 0);
    check(!s_ready, "R1", "s_ready in reset", s_ready, 0);
    check(!underflow_o, "R1", "underflow_o in reset", underflow_o, 0);
  endtask

  task automatic t_clocks();
    int t_rise, t_fall, t_next, t_ws0, t_ws1, rcnt, rrun, rmax;
    do_reset(1'b0, 1'b1);
    nwords = 100;
    words[0] = 32'h1111_2222; words[1] = 32'h3333_4444;
    words[2] = 32'h5555_6666; words[3] = 32'h7777_8888;
    t_rise = 0; t_fall = 0; t_next = 0;
    for (int c = 0; c < 40; c++) begin
      @(negedge clk);
      if (bclk_o && !bclk_prev && t_rise == 0 && c > 10) t_rise = c;
      else if (!bclk_o && bclk_prev && t_rise != 0 && t_fall == 0) t_fall = c;
      else if (bclk_o && !bclk_prev && t_fall != 0 && t_next == 0) t_next = c;
    end
    check(t_next - t_rise == 8, "R2", "bclk period", t_next - t_rise, 8);
    check(t_fall - t_rise == 4, "R2", "bclk high time", t_fall - t_rise, 4);
    t_ws0 = 0; t_ws1 = 0; rcnt = 0; rrun = 0; rmax = 0;
    for (int c = 0; c < 900; c++) begin
      @(negedge clk);
      if (ws_o && !ws_prev) begin
        if (t_ws0 == 0) t_ws0 = c;
        else if (t_ws1 == 0) t_ws1 = c;
      end
      if (c >= 100 && c < 100 + 768) begin
        if (s_ready) begin rcnt++; rrun++; if (rrun > rmax) rmax = rrun; end
        else rrun = 0;
      end
    end
    check(t_ws1 - t_ws0 == 256, "R3", "ws period", t_ws1 - t_ws0, 256);
    check(rcnt == 3, "R4", "ready pulses in 3 frames", rcnt, 3);
    check(rmax == 1, "R4", "ready pulse width", rmax, 1);
  endtask

  task automatic t_left_just();
    int i;
    words[0] = 32'h34FF_1280; words[1] = 32'h0180_FE7F;
    words[2] = 32'hAAAA_5555; words[3] = 32'h0000_0000;
    nwords = 3;
    do_reset(1'b0, 1'b1);
    repeat (4 * 256 + 40) @(posedge clk);
    i = find_edge(1'b1);
    check(i >= 0, "R6", "ws rise found", i, 1);
    if (i >= 0) begin
      check(get_bits(i) == exp_frame(words[0]), "R5", "LJ frame 0",
            get_bits(i), exp_frame(words[0]));
      check(get_bits(i + 32) == exp_frame(words[1]), "R4", "LJ frame 1",
            get_bits(i + 32), exp_frame(words[1]));
      check(get_bits(i + 64) == exp_frame(words[2]), "R5", "LJ frame 2",
            get_bits(i + 64), exp_frame(words[2]));
      check(ws_count(i, 16, 1'b1) == 16 && ws_count(i + 16, 16, 1'b0) == 16,
            "R6", "LJ ws high for left", ws_count(i, 16, 1'b1), 16);
    end
    check(viol == 0, "R3", "ws/sd change off the falling edge", viol, 0);
  endtask

  task automatic t_i2s();
    int j;
    logic [31:0] f0;
    words[0] = 32'h34FF_1280; words[1] = 32'h0180_FE7F;
    words[2] = 32'hAAAA_5555; words[3] = 32'h0000_0000;
    nwords = 3;
    do_reset(1'b1, 1'b1);
    repeat (4 * 256 + 40) @(posedge clk);
    j = find_edge(1'b0);
    check(j >= 0, "R7", "ws fall found", j, 1);
    if (j >= 0) begin
      f0 = exp_frame(words[0]);
      check(sd_a[j] == f0[0], "R7", "slot at ws fall holds prior LSB",
            sd_a[j], f0[0]);
      check(get_bits(j + 1) == exp_frame(words[1]), "R7", "I2S delayed frame",
            get_bits(j + 1), exp_frame(words[1]));
      check(ws_count(j, 16, 1'b0) == 16 && ws_count(j + 16, 16, 1'b1) == 16,
            "R7", "I2S ws low for left", ws_count(j, 16, 1'b0), 16);
    end
    check(viol == 0, "R3", "I2S ws/sd change off the falling edge", viol, 0);
  endtask

  task automatic t_underflow();
    int i;
    words[0] = 32'hC3A5_7E01;
    nwords = 1;
    do_reset(1'b0, 1'b0);
    check(!underflow_o, "R8", "flag clear after reset", underflow_o, 0);
    repeat (100) @(negedge clk);
    check(underflow_o, "R8", "flag set on starved frame", underflow_o, 1);
    widx = 0;
    rdy_seen = 1'b0;
    feed_en = 1'b1;
    repeat (3 * 256) @(posedge clk);
    i = find_edge(1'b1);
    if (i >= 0) begin
      check(get_bits(i) == 32'h0, "R8", "starved frame is silent", get_bits(i), 0);
      check(get_bits(i + 32) == exp_frame(words[0]), "R8", "word after starve",
            get_bits(i + 32), exp_frame(words[0]));
    end else begin
      check(1'b0, "R8", "ws rise found", i, 1);
    end
    @(negedge clk);
    check(underflow_o, "R8", "flag stays set", underflow_o, 1);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    words[0] = '0; words[1] = '0; words[2] = '0; words[3] = '0;
    t_reset();
    t_clocks();
    t_left_just();
    t_i2s();
    t_underflow();
    finish_run();
  end
endmodule